// File: doc/BRIEF.md
# Dual-Capture Edge Timestamp Unit

This block stamps transitions on an external pin with the value of a free-running counter. The pin is brought into the clock domain through a two-flop synchronizer. A 2-bit edge mode selects which transitions count. The first qualifying transition after the unit is armed stores the counter in capture slot 1. The second stores it in capture slot 2. Any later transition is ignored until the unit is armed again.

A request for the interrupt unit is raised on either the first or the second capture, as chosen by a select bit. Software re-arms the unit in one of two ways: it strobes the capture-status clear, or it moves the edge mode from disabled to any enabled setting. Captures happen only while the pin is configured as an input. The counter, interrupt masking and register access are outside this block.

Top module: `edge_stamp_unit`

## Requirements
- R1: Edge mode encoding: 0 disables capture, 1 captures on rising edges only, 2 captures on falling edges only, and 3 captures on both edges.
- R2: No capture and no event occur while `pin_is_input_i` is 0, whatever the pin does.
- R3: After arming, the first qualifying edge loads `cap1_o` and the second loads `cap2_o`. Further edges change neither register until the unit is re-armed.
- R4: With `second_irq_sel_i`=0, `cap_evt_o` pulses for one cycle on the capture into slot 1 only. With it at 1, the pulse comes on the capture into slot 2 only.
- R5: A one-cycle `clr_cap_i` strobe re-arms the unit, so the next qualifying edge loads `cap1_o` again.
- R6: A change of `edge_mode_i` from 0 to any non-zero value re-arms the unit without a clear strobe.
- R7: After reset, `cap1_o`, `cap2_o` and `cap_evt_o` are all zero.
- R8: The stored value is `count_i` as it stands in the cycle after the second rising clock edge that samples the new pin level. The capture register and `cap_evt_o` update on the third such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CW | Free-running counter value |
| pin_i | input | 1 | Asynchronous external pin |
| edge_mode_i | input | 2 | Edge selection (0 off, 1 rise, 2 fall, 3 both) |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| second_irq_sel_i | input | 1 | 0: event on first capture, 1: event on second |
| clr_cap_i | input | 1 | One-cycle capture-status clear strobe (re-arm) |
| cap1_o | output | CW | First capture register |
| cap2_o | output | CW | Second capture register |
| cap_evt_o | output | 1 | One-cycle capture event request |

## Verification
The tests use rising-only, falling-only and both-edge modes. In each mode they use pin sequences that mix qualifying and non-qualifying transitions, so a wrong polarity decode shows up as a stamp in the wrong slot. Third and later edges, edges with the pin set as an output, and edges in the disabled mode must all leave both registers unchanged and raise no event. Re-arming is tested two ways, by the clear strobe and by the mode change from disabled to enabled, which separates the two re-arm paths. Each expected stamp is the counter value two clocks after the pin change, so any extra or missing register in the pipeline changes the stamp.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  // qualifying-edge decode for a previous/current sample pair
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    logic r;
    case (edge_mode_e'(mode))
      EDGE_RISE: r = ~prev & cur;
      EDGE_FALL: r = prev & ~cur;
      EDGE_ANY:  r = prev ^ cur;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_i,
  input  logic [1:0] mode_i,
  output logic       hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sample_i;

  assign hit_o = edge_hit(mode_i, prev_q, sample_i);
endmodule

// File: rtl/cap_slots.sv
module cap_slots #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          rearm_i,
  input  logic          second_sel_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] cap1_o,
  output logic [CW-1:0] cap2_o,
  output logic          evt_o
);
  localparam logic [1:0] IDX_FULL = 2'd2;

  logic [1:0] idx_q;
  logic [1:0] idx_eff;
  logic       take_first;
  logic       take_second;

  assign idx_eff     = rearm_i ? 2'd0 : idx_q;
  assign take_first  = hit_i && (idx_eff == 2'd0);
  assign take_second = hit_i && (idx_eff == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 2'd0;
      cap1_o <= '0;
      cap2_o <= '0;
      evt_o  <= 1'b0;
    end else begin
      if (take_first)  cap1_o <= count_i;
      if (take_second) cap2_o <= count_i;
      idx_q <= take_first ? 2'd1 : (take_second ? IDX_FULL : idx_eff);
      evt_o <= (take_first && !second_sel_i) || (take_second && second_sel_i);
    end
  end

  // R3: once both slots are full, nothing moves until re-armed
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_FULL && !rearm_i) |=> ($stable(cap1_o) && $stable(cap2_o)));

  // R4: an event always follows a qualifying hit
  a_r4_evt_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(hit_i));

  // R5: a re-arm with no edge returns to the first slot
  a_r5_rearm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !hit_i) |=> (idx_q == 2'd0));
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import cap_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          pin_i,
  input  logic [1:0]    edge_mode_i,
  input  logic          pin_is_input_i,
  input  logic          second_irq_sel_i,
  input  logic          clr_cap_i,
  output logic [CW-1:0] cap1_o,
  output logic [CW-1:0] cap2_o,
  output logic          cap_evt_o
);
  logic       pin_sync;
  logic       raw_hit;
  logic       qual_hit;
  logic [1:0] mode_q;
  logic       mode_enable_rearm;
  logic       rearm;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sample_i(pin_sync),
    .mode_i(edge_mode_i), .hit_o(raw_hit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= EDGE_OFF;
    else        mode_q <= edge_mode_i;

  assign mode_enable_rearm = (mode_q == EDGE_OFF) && (edge_mode_i != EDGE_OFF);
  assign rearm    = clr_cap_i || mode_enable_rearm;
  assign qual_hit = raw_hit && pin_is_input_i;

  cap_slots #(.CW(CW)) u_slots (
    .clk(clk), .rst_n(rst_n), .hit_i(qual_hit), .rearm_i(rearm),
    .second_sel_i(second_irq_sel_i), .count_i(count_i),
    .cap1_o(cap1_o), .cap2_o(cap2_o), .evt_o(cap_evt_o)
  );

  // R2: pin as output blocks all captures
  a_r2_output_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input_i |=> ($stable(cap1_o) && $stable(cap2_o) && !cap_evt_o));

  // R1: disabled mode blocks all captures
  a_r1_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i == EDGE_OFF) |=> ($stable(cap1_o) && $stable(cap2_o) && !cap_evt_o));
endmodule

// File: tb/edge_stamp_unit_tb_top.sv
module edge_stamp_unit_tb_top;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt;
  logic          pin = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          is_in = 1'b1;
  logic          sel2 = 1'b0;
  logic          clr = 1'b0;
  logic [CW-1:0] cap1, cap2;
  logic          evt;

  int total = 0;
  int bad   = 0;
  int       slot_q[$];
  logic [CW-1:0] val_q[$];
  logic [CW-1:0] exp1 = '0, exp2 = '0;

  always #2 clk = ~clk;  // 250 MHz

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 32'd100;
    else        cnt <= cnt + 32'd1;

  edge_stamp_unit #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .pin_i(pin),
    .edge_mode_i(mode), .pin_is_input_i(is_in), .second_irq_sel_i(sel2),
    .clr_cap_i(clr), .cap1_o(cap1), .cap2_o(cap2), .cap_evt_o(evt)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops an expected event and compares the stamped slot (R4, R8)
  always @(negedge clk) begin
    if (rst_n && evt) begin
      total++;
      if (slot_q.size() == 0) begin
        bad++;
        $display("FAIL R4 actual=unexpected event expected=none");
      end else begin
        int s;
        logic [CW-1:0] v;
        s = slot_q.pop_front();
        v = val_q.pop_front();
        if (((s == 1) ? cap1 : cap2) !== v) begin
          bad++;
          $display("FAIL R8 actual=%0h expected=%0h (slot %0d)",
                   (s == 1) ? cap1 : cap2, v, s);
        end
      end
    end
  end

  // driver: change the pin; slot 0 means no capture expected
  task automatic drive_edge(input logic lvl, input int slot, input logic ev);
    logic [CW-1:0] stamp;
    @(negedge clk);
    pin = lvl;
    stamp = cnt + 32'd2;
    if (slot == 1) exp1 = stamp;
    if (slot == 2) exp2 = stamp;
    if (ev) begin
      slot_q.push_back(slot);
      val_q.push_back(stamp);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    check("R4 pending", 32'(slot_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 cap1", cap1, '0);
    check("R7 cap2", cap2, '0);
    check("R7 evt", {31'd0, evt}, '0);

    // R1 rising mode, R4 event on first, R3 third edge ignored
    mode = 2'd1; sel2 = 1'b0;
    @(negedge clk);
    drive_edge(1'b1, 1, 1'b1);
    drive_edge(1'b0, 0, 1'b0);          // falling ignored in rise mode
    check("R1 rise-only cap2 untouched", cap2, '0);
    drive_edge(1'b1, 2, 1'b0);
    check("R3 cap1", cap1, exp1);
    check("R3 cap2", cap2, exp2);
    drive_edge(1'b0, 0, 1'b0);
    drive_edge(1'b1, 0, 1'b0);          // third rise
    check("R3 full cap1 held", cap1, exp1);
    check("R3 full cap2 held", cap2, exp2);

    // R5 clear re-arms, falling mode, R4 event on second
    pulse_clr();
    mode = 2'd2; sel2 = 1'b1;
    drive_edge(1'b0, 1, 1'b0);
    drive_edge(1'b1, 0, 1'b0);          // rise ignored in fall mode
    drive_edge(1'b0, 2, 1'b1);
    check("R5 cap1 after clear", cap1, exp1);
    check("R1 fall cap2", cap2, exp2);

    // R1 both edges
    pulse_clr();
    mode = 2'd3; sel2 = 1'b0;
    drive_edge(1'b1, 1, 1'b1);
    drive_edge(1'b0, 2, 1'b0);
    check("R1 both cap1", cap1, exp1);
    check("R1 both cap2", cap2, exp2);

    // R2 pin as output: no capture
    pulse_clr();
    is_in = 1'b0;
    drive_edge(1'b1, 0, 1'b0);
    drive_edge(1'b0, 0, 1'b0);
    check("R2 cap1 held", cap1, exp1);
    check("R2 cap2 held", cap2, exp2);
    is_in = 1'b1;

    // R1 mode off: no capture
    mode = 2'd0;
    drive_edge(1'b1, 0, 1'b0);
    drive_edge(1'b0, 0, 1'b0);
    check("R1 off cap1 held", cap1, exp1);

    // fill both slots, then R6 re-arm through mode enable
    mode = 2'd3;
    @(negedge clk);
    drive_edge(1'b1, 1, 1'b1);
    drive_edge(1'b0, 2, 1'b0);
    drive_edge(1'b1, 0, 1'b0);
    check("R3 full before R6", cap1, exp1);
    mode = 2'd0;
    repeat (2) @(negedge clk);
    mode = 2'd1;
    @(negedge clk);
    drive_edge(1'b0, 0, 1'b0);
    drive_edge(1'b1, 1, 1'b1);
    check("R6 cap1 after enable", cap1, exp1);
    check("R6 cap2 kept", cap2, exp2);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule